// File: doc/BRIEF.md
# Four-Point Lossless Integer Lifting Transform

This block computes a four-point integer transform that approximates the DCT. It uses only additions, subtractions and arithmetic right shifts, so it has no multipliers. A butterfly stage comes first. After it, the even half is handled by a pair of lifting steps and the odd half by two shift-built lifting steps. Each lifting step changes one operand using only the other operand, so the inverse can undo every step exactly. The odd-half lifting steps use the constants 7/16 and 3/8. The mapping is integer to integer and exactly reversible. For every input made of 12-bit samples, every internal node and every coefficient fits in a 16-bit signed word.

The block has one mode input. In forward mode, four samples become four coefficients. In inverse mode, four coefficients become the original four samples. The mode is sampled along with each vector, so forward and inverse vectors may be interleaved on consecutive cycles. Each accepted vector produces a result exactly one clock later on a 16-bit-per-lane output bus, in natural coefficient order. The lifting lattice produces the coefficients in a different internal order, and the block reorders them before the output.

Top module: `xf4_lift_core`

## Requirements
- R1: A synchronous active-high reset clears `out_valid` to 0 and every output lane to 0. Both stay at 0 until a vector is accepted.
- R2: `out_valid` is high in exactly the cycle that follows a cycle with `in_valid` high. The result of the vector accepted in cycle n is on `out_data` in cycle n+1.
- R3: In forward mode, every input lane must lie in [-2048, 2047]. For such inputs, every butterfly and lifting node and every coefficient fits in a 16-bit signed word without wrapping.
- R4: Forward even half. With the sums a0 = x0+x3 and a1 = x1+x2, the outputs are Y2 = a0 - a1 and Y0 = a0 - floor(Y2/2).
- R5: Forward odd half. With the differences a3 = x0-x3 and a2 = x1-x2, the outputs are Y3 = a2 - P(a3) and Y1 = a3 + U(Y3). Here P(v) = floor(v/2) - floor(v/16) and U(v) = floor(v/2) - floor(v/8).
- R6: Lane k of a bus occupies bits [16k+15:16k]. In forward mode, output lanes 0..3 carry Y0, Y1, Y2, Y3 in that order. In inverse mode, input lanes 0..3 carry Y0..Y3 and output lanes 0..3 carry x0..x3.
- R7: Inverse mode applied to any forward result of in-range samples returns the original four samples bit-exactly.
- R8: `in_mode` (0 = forward, 1 = inverse) is taken together with each accepted vector. Consecutive vectors of different modes are each transformed in their own mode.
- R9: While `in_valid` is low, `in_data` and `in_mode` are ignored and `out_data` holds its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input vector strobe |
| in_mode | input | 1 | 0 = forward, 1 = inverse |
| in_data | input | 64 | Four signed 16-bit lanes, lane k at bits [16k+15:16k] |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_data | output | 64 | Four signed 16-bit result lanes |

## Verification
The datapath is combinational up to a single output register. Any fault in a butterfly, lifting or shift term therefore shows on `out_data` in the cycle right after the vector is accepted. It shows as a wrong coefficient in forward mode, or as a failed round trip in inverse mode. A wrong floor or a swapped lane is most visible on negative and extreme samples. For that reason every combination of six boundary values across all four lanes is swept, and each forward result is fed back through inverse mode. Wrapping in a 16-bit node shows up as a large mismatch on the same cycle, and in-design checks on guard-widened nodes catch it before truncation.

// File: rtl/xf4_pkg.sv
package xf4_pkg;
    // Transform geometry: the lattice below is defined for four lanes.
    localparam int LANES    = 4;
    localparam int PAIRS    = LANES / 2;
    localparam int SAMPLE_W = 12;
    localparam int COEF_W   = 16;
    localparam int GUARD    = 2;
    localparam int NODE_W   = COEF_W + GUARD;
    localparam int SMAX     = (1 << (SAMPLE_W - 1)) - 1;
    localparam int SMIN     = -(1 << (SAMPLE_W - 1));

    typedef logic signed [NODE_W-1:0] node_t;
    typedef logic signed [COEF_W-1:0] coef_t;

    typedef enum logic {XF_FWD = 1'b0, XF_INV = 1'b1} xf_mode_e;

    // Lattice values in the order the lifting chain produces them.
    typedef struct packed {
        node_t e0;
        node_t e2;
        node_t t;
        node_t o1;
    } lattice_t;

    // First odd-half constant, 7/16 = 1/2 - 1/16, floor semantics.
    function automatic node_t lift_p(input node_t v);
        return (v >>> 1) - (v >>> 4);
    endfunction

    // Second odd-half constant, 3/8 = 1/2 - 1/8, floor semantics.
    function automatic node_t lift_u(input node_t v);
        return (v >>> 1) - (v >>> 3);
    endfunction

    function automatic node_t widen(input coef_t c);
        return node_t'(c);
    endfunction

    // True when the node survives truncation to a coefficient word.
    function automatic logic fits_coef(input node_t v);
        return v == node_t'(coef_t'(v));
    endfunction

    function automatic logic in_sample_range(input coef_t c);
        return (int'(c) >= SMIN) && (int'(c) <= SMAX);
    endfunction
endpackage

// File: rtl/xf4_pair.sv
// Butterfly on one lane pair. Forward: (p,q) -> (p+q, p-q).
// Inverse: (sum,diff) -> (p,q); the halving is exact since both share parity.
module xf4_pair
    import xf4_pkg::*;
#(
    parameter bit INVERSE = 1'b0
) (
    input  node_t in_a,
    input  node_t in_b,
    output node_t out_a,
    output node_t out_b
);
    generate
        if (INVERSE) begin : g_inv
            node_t half;
            assign half  = (in_a + in_b) >>> 1;
            assign out_a = half;
            assign out_b = half - in_b;
        end else begin : g_fwd
            assign out_a = in_a + in_b;
            assign out_b = in_a - in_b;
        end
    endgenerate
endmodule

// File: rtl/xf4_even_lift.sv
// Even-half lifting pair.
// Forward: p_in=a0, q_in=a1 -> p_out=Y0, q_out=Y2.
// Inverse: p_in=Y0, q_in=Y2 -> p_out=a0, q_out=a1.
module xf4_even_lift
    import xf4_pkg::*;
#(
    parameter bit INVERSE = 1'b0
) (
    input  node_t p_in,
    input  node_t q_in,
    output node_t p_out,
    output node_t q_out
);
    generate
        if (INVERSE) begin : g_inv
            node_t base;
            assign base  = p_in + (q_in >>> 1);
            assign p_out = base;
            assign q_out = base - q_in;
        end else begin : g_fwd
            node_t diff;
            assign diff  = p_in - q_in;
            assign q_out = diff;
            assign p_out = p_in - (diff >>> 1);
        end
    endgenerate
endmodule

// File: rtl/xf4_odd_lift.sv
// Odd-half lifting pair with shift-built constants.
// Forward: p_in=a3, q_in=a2 -> p_out=Y1, q_out=Y3.
// Inverse: p_in=Y1, q_in=Y3 -> p_out=a3, q_out=a2.
module xf4_odd_lift
    import xf4_pkg::*;
#(
    parameter bit INVERSE = 1'b0
) (
    input  node_t p_in,
    input  node_t q_in,
    output node_t p_out,
    output node_t q_out
);
    generate
        if (INVERSE) begin : g_inv
            node_t rec;
            assign rec   = p_in - lift_u(q_in);
            assign p_out = rec;
            assign q_out = q_in + lift_p(rec);
        end else begin : g_fwd
            node_t mid;
            assign mid   = q_in - lift_p(p_in);
            assign q_out = mid;
            assign p_out = p_in + lift_u(mid);
        end
    endgenerate
endmodule

// File: rtl/xf4_lift_core.sv
module xf4_lift_core
    import xf4_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic                    in_mode,
    input  logic [LANES*COEF_W-1:0] in_data,
    output logic                    out_valid,
    output logic [LANES*COEF_W-1:0] out_data
);
    xf_mode_e mode;
    assign mode = xf_mode_e'(in_mode);

    node_t lane_n [LANES];
    logic  lane_ok [LANES];

    generate
        for (genvar k = 0; k < LANES; k++) begin : g_unpack
            coef_t raw;
            assign raw        = coef_t'(in_data[k*COEF_W +: COEF_W]);
            assign lane_n[k]  = widen(raw);
            assign lane_ok[k] = in_sample_range(raw);
        end
    endgenerate

    // ---------------- forward chain ----------------
    node_t fb_sum [PAIRS];
    node_t fb_dif [PAIRS];

    generate
        for (genvar k = 0; k < PAIRS; k++) begin : g_fwd_bfly
            xf4_pair #(.INVERSE(1'b0)) u_pair (
                .in_a  (lane_n[k]),
                .in_b  (lane_n[LANES-1-k]),
                .out_a (fb_sum[k]),
                .out_b (fb_dif[k])
            );
        end
    endgenerate

    node_t f_e0, f_e2, f_o1, f_t;

    xf4_even_lift #(.INVERSE(1'b0)) u_fwd_even (
        .p_in  (fb_sum[0]),
        .q_in  (fb_sum[1]),
        .p_out (f_e0),
        .q_out (f_e2)
    );

    xf4_odd_lift #(.INVERSE(1'b0)) u_fwd_odd (
        .p_in  (fb_dif[0]),
        .q_in  (fb_dif[1]),
        .p_out (f_o1),
        .q_out (f_t)
    );

    lattice_t fwd_lat;
    assign fwd_lat = '{e0: f_e0, e2: f_e2, t: f_t, o1: f_o1};

    // Lattice order e0,e2,t,o1 -> natural order Y0..Y3.
    node_t fwd_y [LANES];
    always_comb begin
        fwd_y[0] = fwd_lat.e0;
        fwd_y[1] = fwd_lat.o1;
        fwd_y[2] = fwd_lat.e2;
        fwd_y[3] = fwd_lat.t;
    end

    // ---------------- inverse chain ----------------
    lattice_t inv_lat;
    assign inv_lat = '{e0: lane_n[0], e2: lane_n[2], t: lane_n[3], o1: lane_n[1]};

    node_t ib_sum [PAIRS];
    node_t ib_dif [PAIRS];

    xf4_even_lift #(.INVERSE(1'b1)) u_inv_even (
        .p_in  (inv_lat.e0),
        .q_in  (inv_lat.e2),
        .p_out (ib_sum[0]),
        .q_out (ib_sum[1])
    );

    xf4_odd_lift #(.INVERSE(1'b1)) u_inv_odd (
        .p_in  (inv_lat.o1),
        .q_in  (inv_lat.t),
        .p_out (ib_dif[0]),
        .q_out (ib_dif[1])
    );

    node_t inv_x [LANES];

    generate
        for (genvar k = 0; k < PAIRS; k++) begin : g_inv_bfly
            xf4_pair #(.INVERSE(1'b1)) u_pair (
                .in_a  (ib_sum[k]),
                .in_b  (ib_dif[k]),
                .out_a (inv_x[k]),
                .out_b (inv_x[LANES-1-k])
            );
        end
    endgenerate

    // ---------------- result register ----------------
    coef_t res_q [LANES];

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            for (int k = 0; k < LANES; k++) res_q[k] <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                for (int k = 0; k < LANES; k++)
                    res_q[k] <= (mode == XF_INV) ? coef_t'(inv_x[k]) : coef_t'(fwd_y[k]);
            end
        end
    end

    generate
        for (genvar k = 0; k < LANES; k++) begin : g_pack
            assign out_data[k*COEF_W +: COEF_W] = res_q[k];
        end
    endgenerate

    // ---------------- assertions ----------------
    logic all_in_range;
    logic fwd_nodes_fit;
    always_comb begin
        all_in_range = 1'b1;
        for (int k = 0; k < LANES; k++) all_in_range &= lane_ok[k];
        fwd_nodes_fit = fits_coef(f_e0) & fits_coef(f_e2) & fits_coef(f_o1) & fits_coef(f_t);
        for (int k = 0; k < PAIRS; k++)
            fwd_nodes_fit &= fits_coef(fb_sum[k]) & fits_coef(fb_dif[k]);
    end

    p_valid_follows_r2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    p_valid_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    p_hold_when_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_data));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode == XF_FWD && all_in_range) |-> fwd_nodes_fit);

    // Even lifting output recovers the butterfly sum it was built from (R4).
    p_even_recover_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode == XF_FWD) |-> (f_e0 + (f_e2 >>> 1)) == fb_sum[0]);

    // Odd lifting output recovers the butterfly difference (R5).
    p_odd_recover_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode == XF_FWD) |-> (f_o1 - lift_u(f_t)) == fb_dif[0]);
endmodule

// File: tb/tb_xf4_lift_core.sv
`timescale 1ns/1ps
module tb_xf4_lift_core;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_mode = 1'b0;
    logic [63:0] in_data = '0;
    logic        out_valid;
    logic [63:0] out_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    xf4_lift_core dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_mode(in_mode),
        .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
    );

    // Behavioural reference: returns Y0..Y3 and the largest node magnitude.
    task automatic ref_fwd(input int x[4], output int y[4], output int peak);
        int a0, a1, a2, a3, e0, e2, t, o1;
        a0 = x[0] + x[3]; a3 = x[0] - x[3];
        a1 = x[1] + x[2]; a2 = x[1] - x[2];
        e2 = a0 - a1;     e0 = a0 - (e2 >>> 1);
        t  = a2 - ((a3 >>> 1) - (a3 >>> 4));
        o1 = a3 + ((t >>> 1) - (t >>> 3));
        y[0] = e0; y[1] = o1; y[2] = e2; y[3] = t;
        peak = 0;
        foreach (y[i]) if ((y[i] < 0 ? -y[i] : y[i]) > peak) peak = (y[i] < 0 ? -y[i] : y[i]);
        if ((a0 < 0 ? -a0 : a0) > peak) peak = (a0 < 0 ? -a0 : a0);
        if ((a1 < 0 ? -a1 : a1) > peak) peak = (a1 < 0 ? -a1 : a1);
        if ((a2 < 0 ? -a2 : a2) > peak) peak = (a2 < 0 ? -a2 : a2);
        if ((a3 < 0 ? -a3 : a3) > peak) peak = (a3 < 0 ? -a3 : a3);
    endtask

    task automatic drive(input bit mode, input int v[4]);
        in_mode  = mode;
        in_valid = 1'b1;
        for (int k = 0; k < 4; k++) in_data[16*k +: 16] = v[k][15:0];
    endtask

    task automatic read_out(output int y[4]);
        for (int k = 0; k < 4; k++) y[k] = int'($signed(out_data[16*k +: 16]));
    endtask

    task automatic cmp(input string req, input int got[4], input int exp[4]);
        bit bad = 1'b0;
        checks++;
        for (int k = 0; k < 4; k++) if (got[k] != exp[k]) bad = 1'b1;
        if (bad) begin
            fails++;
            $display("FAIL %s got %0d %0d %0d %0d expected %0d %0d %0d %0d", req,
                     got[0], got[1], got[2], got[3], exp[0], exp[1], exp[2], exp[3]);
        end
    endtask

    task automatic check_bit(input string req, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got %0b expected %0b", req, got, exp);
        end
    endtask

    // Forward a vector, check it, then feed the expected coefficients back.
    task automatic round_trip(input int x[4]);
        int y[4], got[4], peak;
        ref_fwd(x, y, peak);
        checks++;
        if (peak > 32767) begin
            fails++;
            $display("FAIL R3 node magnitude %0d expected <= 32767", peak);
        end
        @(negedge clk); drive(1'b0, x);
        @(negedge clk); in_valid = 1'b0;
        check_bit("R2 out_valid after forward", out_valid, 1'b1);
        read_out(got);
        cmp("R4 R5 forward coefficients", got, y);
        drive(1'b1, y);
        @(negedge clk); in_valid = 1'b0;
        read_out(got);
        cmp("R7 inverse round trip", got, x);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired before completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        int got[4], exp[4], zero[4], held[4];
        int vals[6] = '{-2048, -2047, -1, 0, 1, 2047};
        zero = '{0, 0, 0, 0};

        // R1: reset state
        repeat (3) @(negedge clk);
        check_bit("R1 out_valid in reset", out_valid, 1'b0);
        read_out(got); cmp("R1 out_data in reset", got, zero);
        rst = 1'b0;
        @(negedge clk);
        check_bit("R1 out_valid after reset", out_valid, 1'b0);

        // R6: lane order, single impulse in lane 0
        drive(1'b0, '{100, 0, 0, 0});
        @(negedge clk); in_valid = 1'b0;
        read_out(got); exp = '{50, 84, 100, -44};
        cmp("R6 natural lane order", got, exp);
        // R4: flat input lands only in Y0
        drive(1'b0, '{1000, 1000, 1000, 1000});
        @(negedge clk); in_valid = 1'b0;
        read_out(got); exp = '{2000, 0, 0, 0};
        cmp("R4 flat input", got, exp);

        // R9: idle cycles ignore data and mode
        held = got;
        for (int c = 0; c < 4; c++) begin
            in_mode = c[0];
            in_data = {$urandom, $urandom};
            @(negedge clk);
            check_bit("R9 out_valid idle", out_valid, 1'b0);
            read_out(got); cmp("R9 out_data held", got, held);
        end

        // R8: back-to-back forward then inverse
        begin
            int xa[4], xb[4], ya[4], yb[4], pk;
            xa = '{-2048, 2047, 5, -7};
            xb = '{300, -1200, 17, 2047};
            ref_fwd(xa, ya, pk);
            ref_fwd(xb, yb, pk);
            @(negedge clk); drive(1'b0, xa);
            @(negedge clk); drive(1'b1, yb);
            read_out(got); cmp("R8 forward before inverse", got, ya);
            @(negedge clk); drive(1'b0, xb);
            read_out(got); cmp("R8 inverse after forward", got, xb);
            @(negedge clk); in_valid = 1'b0;
            read_out(got); cmp("R8 forward after inverse", got, yb);
        end

        // Extremes: every combination of six boundary values
        foreach (vals[a]) foreach (vals[b]) foreach (vals[c]) foreach (vals[d])
            round_trip('{vals[a], vals[b], vals[c], vals[d]});

        // Random 12-bit vectors
        for (int n = 0; n < 2500; n++) begin
            int x[4];
            for (int k = 0; k < 4; k++) x[k] = int'($urandom % 4096) - 2048;
            round_trip(x);
        end

        // R1: reset in mid-run clears outputs
        @(negedge clk); drive(1'b0, '{2047, -2048, 2047, -2048});
        rst = 1'b1;
        @(negedge clk); in_valid = 1'b0;
        check_bit("R1 out_valid after mid-run reset", out_valid, 1'b0);
        read_out(got); cmp("R1 out_data after mid-run reset", got, zero);
        rst = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule